// File: doc/BRIEF.md
# SDRAM Read/Write Data Pipeline with Byte Masking

This block sits between the column-command logic of a synchronous DRAM and its bidirectional data bus. A read strobe arrives with its word. The word is held back by the programmed CAS latency of one, two or three clocks and then driven out with an output enable. Write data goes straight through in the cycle it is presented, and a per-lane write enable comes with it.

A mask input gates each byte lane. On a 16-bit bus there is one mask bit per byte; a bus of 8 bits or fewer has a single mask bit. The same mask pins act differently by direction. For reads, a mask sampled in one cycle turns off the output of its lane two cycles later. For writes, a mask blocks its lane in the same cycle. A valid bit travels down the read delay line with the data, so the enable always lines up with the word. A new latency setting is taken only while no read is in flight.

Top module: `sdram_dq_pipe`

## Requirements
- R1: After reset no lane is enabled, `dq_out` is zero, `wr_en` is zero, and the read latency is 3.
- R2: A read strobe in cycle k produces its word on `dq_out`, with `dq_oe` high, in cycle k+L, where L is the latency in effect in cycle k+L. In every other cycle `dq_oe` stays low.
- R3: Read strobes in consecutive cycles produce words in consecutive cycles, with no gap and no merging, for each latency.
- R4: If `dqm[i]` is high in cycle m, read lane i is disabled in cycle m+2 and its `dq_out` bits are zero, whatever the latency.
- R5: In the same cycle, `wr_en[i]` equals `wr_valid & ~dqm[i]`, and `wr_dq` equals `wr_data`.
- R6: `cas_lat` values 1..3 are taken at a clock edge only if no read strobe was accepted in the three cycles before that edge. The value 0 is always ignored and leaves the current latency unchanged.
- R7: A read and a write can be active at once with one `dqm` value. The write uses the mask of the current cycle and the read uses the mask of two cycles earlier.
- R8: Lane i covers data bits [8*i+7 : 8*i]. For the 16-bit default, `dqm[0]` is the low byte and `dqm[1]` is the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 2 | Requested read latency (1..3, 0 ignored) |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | DQ_W | Read word from the array |
| wr_valid | input | 1 | Write data strobe |
| wr_data | input | DQ_W | Write word from the bus |
| dqm | input | LANES | Active-high lane mask |
| dq_out | output | DQ_W | Driven read word, zero in disabled lanes |
| dq_oe | output | LANES | Per-lane output enable |
| wr_en | output | LANES | Per-lane write enable to the array |
| wr_dq | output | DQ_W | Write word to the array |

## Verification
The mask of a write and the delayed mask of a read can fall in the same cycle, and they need not agree. The bench provokes this by running reads and writes together while `dqm` changes every cycle. For each cycle it predicts the write enables from the current mask and the read enables from the mask of two cycles earlier, each lane separately. Latency changes arrive at random in the same run, so the rule that holds the latency while reads are in flight is checked against the masking as well.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;
    localparam int MAX_CL      = 3;
    localparam int RD_MASK_LAT = 2;
    localparam int BYTE_W      = 8;

    typedef logic [1:0] cl_t;

    function automatic int lane_count(input int width);
        return (width > BYTE_W) ? width / BYTE_W : 1;
    endfunction

    function automatic logic cl_legal(input cl_t c);
        return (c != 2'd0);
    endfunction
endpackage

// File: rtl/sdram_cl_ctrl.sv
module sdram_cl_ctrl
    import sdram_dq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cl_t  cas_lat,
    input  logic busy,
    output cl_t  cl_eff
);
    always_ff @(posedge clk) begin
        if (rst)
            cl_eff <= cl_t'(MAX_CL);
        else if (!busy && cl_legal(cas_lat))
            cl_eff <= cas_lat;
    end
endmodule

// File: rtl/sdram_rd_delay.sv
module sdram_rd_delay
    import sdram_dq_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int DEPTH = MAX_CL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [DQ_W-1:0] in_data,
    input  cl_t             sel,
    output logic            out_vld,
    output logic [DQ_W-1:0] out_data,
    output logic            busy
);
    typedef struct packed {
        logic            vld;
        logic [DQ_W-1:0] data;
    } slot_t;

    slot_t            stage [DEPTH];
    logic [DEPTH-1:0] vld_vec;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= '{vld: in_vld, data: in_data};
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
        assign vld_vec[s] = stage[s].vld;
    end

    assign busy = |vld_vec;

    always_comb begin
        out_vld  = 1'b0;
        out_data = '0;
        for (int s = 0; s < DEPTH; s++) begin
            if (int'(sel) == s + 1) begin
                out_vld  = stage[s].vld;
                out_data = stage[s].data;
            end
        end
    end
endmodule

// File: rtl/sdram_mask_pipe.sv
module sdram_mask_pipe
    import sdram_dq_pkg::*;
#(
    parameter int LANES = 2,
    parameter int LAT   = RD_MASK_LAT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] dqm_late
);
    logic [LANES-1:0] tap [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)         tap[s] <= '0;
            else if (s == 0) tap[s] <= dqm;
            else             tap[s] <= tap[(s == 0) ? 0 : s-1];
        end
    end

    assign dqm_late = tap[LAT-1];
endmodule

// File: rtl/sdram_wr_gate.sv
module sdram_wr_gate #(
    parameter int LANES = 2
) (
    input  logic             wr_valid,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] wr_en
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_en[i] = wr_valid & ~dqm[i];
    end
endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
    import sdram_dq_pkg::*;
#(
    parameter  int DQ_W   = 16,
    localparam int LANES  = lane_count(DQ_W),
    localparam int LANE_W = DQ_W / LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cas_lat,
    input  logic             rd_valid,
    input  logic [DQ_W-1:0]  rd_data,
    input  logic             wr_valid,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [LANES-1:0] dqm,
    output logic [DQ_W-1:0]  dq_out,
    output logic [LANES-1:0] dq_oe,
    output logic [LANES-1:0] wr_en,
    output logic [DQ_W-1:0]  wr_dq
);
    cl_t              cl_eff;
    logic             busy;
    logic             sel_vld;
    logic [DQ_W-1:0]  sel_data;
    logic [LANES-1:0] dqm_late;

    sdram_cl_ctrl u_cl (
        .clk     (clk),
        .rst     (rst),
        .cas_lat (cas_lat),
        .busy    (busy),
        .cl_eff  (cl_eff)
    );

    sdram_rd_delay #(.DQ_W(DQ_W), .DEPTH(MAX_CL)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (rd_valid),
        .in_data  (rd_data),
        .sel      (cl_eff),
        .out_vld  (sel_vld),
        .out_data (sel_data),
        .busy     (busy)
    );

    sdram_mask_pipe #(.LANES(LANES), .LAT(RD_MASK_LAT)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .dqm      (dqm),
        .dqm_late (dqm_late)
    );

    sdram_wr_gate #(.LANES(LANES)) u_wr (
        .wr_valid (wr_valid),
        .dqm      (dqm),
        .wr_en    (wr_en)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign dq_oe[i] = sel_vld & ~dqm_late[i];
        assign dq_out[i*LANE_W +: LANE_W] =
            dq_oe[i] ? sel_data[i*LANE_W +: LANE_W] : '0;
    end

    assign wr_dq = wr_data;
endmodule

// File: rtl/sdram_dq_pipe_chk.sv
module sdram_dq_pipe_chk #(
    parameter int DQ_W  = 16,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_valid,
    input logic             wr_valid,
    input logic [LANES-1:0] dqm,
    input logic [LANES-1:0] dq_oe,
    input logic [LANES-1:0] wr_en,
    input logic [DQ_W-1:0]  dq_out,
    input logic [1:0]       cl_eff,
    input logic             busy
);
    localparam int LANE_W = DQ_W / LANES;
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)             cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_wr_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en & dqm) == '0);
    p_wr_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> wr_en == '0);
    p_rd_mask_r4: assert property (@(posedge clk) disable iff (rst)
        cyc == 2'd3 |-> (dq_oe & $past(dqm, 2)) == '0);
    p_rd_origin_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && dq_oe != '0) |->
        ($past(rd_valid) || $past(rd_valid, 2) || $past(rd_valid, 3)));
    p_cl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && $past(busy)) |-> $stable(cl_eff));
    p_cl_legal_r6: assert property (@(posedge clk) disable iff (rst)
        cl_eff != 2'd0);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        p_lane_zero_r8: assert property (@(posedge clk) disable iff (rst)
            !dq_oe[i] |-> dq_out[i*LANE_W +: LANE_W] == '0);
    end
endmodule

bind sdram_dq_pipe sdram_dq_pipe_chk #(.DQ_W(DQ_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .wr_valid (wr_valid),
    .dqm      (dqm),
    .dq_oe    (dq_oe),
    .wr_en    (wr_en),
    .dq_out   (dq_out),
    .cl_eff   (cl_eff),
    .busy     (busy)
);

// File: tb/test_sdram_dq_pipe.sv
module test_sdram_dq_pipe;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cas_lat = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  dqm = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [1:0]  wr_en;
    logic [15:0] wr_dq;

    always #5 clk = ~clk;

    sdram_dq_pipe #(.DQ_W(16)) i_sdram_dq_pipe (
        .clk(clk), .rst(rst), .cas_lat(cas_lat), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_data(wr_data),
        .dqm(dqm), .dq_out(dq_out), .dq_oe(dq_oe), .wr_en(wr_en), .wr_dq(wr_dq)
    );

    int unsigned checks = 0, fails = 0;
    int n = 0;
    int clm = 3;
    logic        hv [0:4095];
    logic [15:0] hd [0:4095];
    logic [1:0]  hm [0:4095];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic [15:0] rd,
                        input logic wv, input logic [15:0] wd,
                        input logic [1:0] m, input logic [1:0] cl,
                        input string req);
        logic        ev;
        logic [15:0] ed, edq;
        logic [1:0]  em2, eoe, ewe;
        bit          busy;
        @(negedge clk);
        rd_valid = rv; rd_data = rd; wr_valid = wv; wr_data = wd;
        dqm = m; cas_lat = cl;
        #1;
        ev  = (n >= clm) ? hv[n-clm] : 1'b0;
        ed  = (n >= clm) ? hd[n-clm] : '0;
        em2 = (n >= 2) ? hm[n-2] : '0;
        for (int i = 0; i < 2; i++) eoe[i] = ev & ~em2[i];
        edq = {eoe[1] ? ed[15:8] : 8'h00, eoe[0] ? ed[7:0] : 8'h00};
        ewe = {wv & ~m[1], wv & ~m[0]};
        chk(dq_oe == eoe, req, "dq_oe", 32'(dq_oe), 32'(eoe));
        chk(dq_out == edq, req, "dq_out", 32'(dq_out), 32'(edq));
        chk(wr_en == ewe, req, "wr_en", 32'(wr_en), 32'(ewe));
        chk(wr_dq == wd, req, "wr_dq", 32'(wr_dq), 32'(wd));
        hv[n] = rv; hd[n] = rd; hm[n] = m;
        busy = 1'b0;
        for (int k = 1; k <= 3; k++) if (n >= k && hv[n-k]) busy = 1'b1;
        if (!busy && cl != 2'd0) clm = int'(cl);
        n++;
    endtask

    task automatic idle(input int cyc, input logic [1:0] cl, input string req);
        for (int c = 0; c < cyc; c++) step(1'b0, '0, 1'b0, '0, 2'b00, cl, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, then a read with cas_lat 0 keeps latency 3
        idle(3, 2'd0, "R1");
        step(1'b1, 16'hA55A, 1'b0, '0, 2'b00, 2'd0, "R1");
        idle(5, 2'd0, "R1");
        // R2: single reads at each latency
        for (int cl = 1; cl <= 3; cl++) begin
            idle(4, 2'(cl), "R2");
            step(1'b1, 16'(16'h1100 * cl + 16'h0033), 1'b0, '0, 2'b00, 2'(cl), "R2");
            idle(5, 2'(cl), "R2");
        end
        // R3: gapless bursts
        for (int cl = 1; cl <= 3; cl++) begin
            idle(4, 2'(cl), "R3");
            for (int b = 0; b < 8; b++)
                step(1'b1, 16'($urandom), 1'b0, '0, 2'b00, 2'(cl), "R3");
            idle(5, 2'(cl), "R3");
        end
        // R4: read masking under changing dqm
        for (int cl = 1; cl <= 3; cl++) begin
            idle(4, 2'(cl), "R4");
            for (int b = 0; b < 24; b++)
                step(1'b1, 16'($urandom), 1'b0, '0, 2'($urandom), 2'(cl), "R4");
            idle(5, 2'(cl), "R4");
        end
        // R5: writes with all mask combinations
        for (int b = 0; b < 32; b++)
            step(1'b0, '0, 1'(b % 3 != 0), 16'($urandom), 2'(b), 2'd0, "R5");
        // R6: latency requests change while reads come and go
        for (int b = 0; b < 300; b++)
            step(1'($urandom % 3 == 0), 16'($urandom), 1'b0, '0, 2'b00,
                 2'($urandom), "R6");
        // R7: reads, writes, masks and latency all random together
        for (int b = 0; b < 600; b++)
            step(1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
                 2'($urandom), 2'($urandom % 8 == 0 ? $urandom : 0), "R7");
        // R8: fixed single-lane masks
        for (int p = 1; p <= 2; p++) begin
            idle(4, 2'd2, "R8");
            for (int b = 0; b < 6; b++)
                step(1'b1, 16'hC3A5 ^ 16'(b), 1'b1, 16'h5A3C ^ 16'(b), 2'(p), 2'd2, "R8");
            idle(5, 2'd2, "R8");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule